// File: doc/BRIEF.md
# Control Endpoint Enumeration Responder

This block sits behind the packet layer of a full-speed USB function. It handles the standard requests on the default control pipe entirely in logic, so enumeration needs no processor. Each SETUP packet arrives as eight decoded bytes. The block decodes them and takes one of four actions. It streams a descriptor or the current configuration value as IN data through a valid/ready byte handshake. It asks for a zero-length status stage. Or it stalls the endpoint.

Descriptor contents are computed from parameters into a constant ROM. The ROM holds an 18-byte device descriptor and a 25-byte configuration block, which is the configuration, interface and endpoint descriptors packed together. Neither is longer than one 64-byte control packet, so every data stage is a single packet. The reply is cut to the length the host asked for. A new device address is applied only once the status stage of its request has completed. A bus reset returns the function to address 0 and unconfigured.

The packet layer reports completion of each status stage on `status_ack_i`. For read requests this is the host's zero-length OUT. For write requests it is the block's zero-length IN.

Top module: `ctl_enum_responder`

## Requirements
- R1: After `rst_ni` is released, `dev_addr_o` and `config_o` are 0 and none of `in_valid_o`, `status_in_o`, `status_out_o`, `stall_o` is asserted.
- R2: A SETUP is eight bytes strobed by `setup_valid_i`, the first one flagged by `setup_first_i`. The fields are, in order: request type (byte 0), request code (byte 1), value (bytes 2-3), index (bytes 4-5), length (bytes 6-7). Multi-byte fields are little-endian, low byte first.
- R3: Request type 80h with code 06h, value high byte 01h and value low byte 0 returns the 18-byte device descriptor. In it, byte 0 = 18, byte 1 = 1, byte 7 = 64 (control packet size), and bytes 8-11 = 34h 12h 78h 56h (vendor 1234h, product 5678h, low byte first).
- R4: The same request with value high byte 02h returns the 25-byte configuration block. Byte 0 = 9, byte 1 = 2, bytes 2-3 = 25, 0. The interface descriptor starts at byte 9 (9, 4) and the endpoint descriptor at byte 18 (7, 5).
- R5: A data stage carries min(length field, stored length) bytes. A length field of 0 skips the data stage and goes straight to the status stage.
- R6: `in_last_o` is asserted only with the final data byte. After that byte, `status_out_o` holds until `status_ack_i`, and then the block goes idle.
- R7: Request type 00h with code 05h, value < 128, and index and length both 0, asserts `status_in_o`. `dev_addr_o` keeps its old value until `status_ack_i`, then takes the new value.
- R8: Request type 00h with code 09h and value 0 or 1 loads `config_o` with that value and asserts `status_in_o`. Any other value stalls and leaves `config_o` unchanged.
- R9: Request type 80h with code 08h returns one data byte equal to `config_o`.
- R10: Any other request, an unknown descriptor type (for example 03h), or a non-zero index field asserts `stall_o`. The stall holds until the first byte of the next SETUP.
- R11: The first byte of a new SETUP aborts any stage in progress, and the new request is then served.
- R12: `bus_reset_i` clears `dev_addr_o` and `config_o` to 0 and idles the endpoint.
- R13: While `in_ready_i` is low, `in_valid_o` and `in_data_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | USB bus reset detected |
| setup_valid_i | input | 1 | SETUP byte strobe |
| setup_first_i | input | 1 | Marks byte 0 of a SETUP |
| setup_byte_i | input | 8 | SETUP byte |
| in_ready_i | input | 1 | Packet layer accepts the IN data byte |
| in_valid_o | output | 1 | IN data byte available |
| in_data_o | output | 8 | IN data byte |
| in_last_o | output | 1 | Final byte of the data stage |
| status_in_o | output | 1 | Awaiting zero-length IN status |
| status_out_o | output | 1 | Awaiting zero-length OUT status |
| status_ack_i | input | 1 | Status stage completed |
| stall_o | output | 1 | Control endpoint stalled |
| dev_addr_o | output | 7 | Device address |
| config_o | output | 8 | Active configuration value |

## Verification
Several rules are checked by assertions on every cycle. The address may change only after a status acknowledge or a bus reset. A bus reset must leave address and configuration at zero. At most one endpoint phase may be active at a time. The last-byte flag must coincide with valid data. Offered data must hold under backpressure. The remaining count may never exceed one packet. Only the bench scenarios can show the values of particular descriptor bytes, the truncation to the requested length, the field byte order, and which requests stall.

// File: rtl/ctl_enum_pkg.sv
package ctl_enum_pkg;
  localparam int SETUP_BYTES = 8;
  localparam int DEV_LEN     = 18;
  localparam int CFG_LEN     = 25;
  localparam int ROM_DEPTH   = DEV_LEN + CFG_LEN;
  localparam int ROM_AW      = $clog2(ROM_DEPTH);

  localparam logic [7:0] RT_STD_IN  = 8'h80;
  localparam logic [7:0] RT_STD_OUT = 8'h00;
  localparam logic [7:0] RQ_SET_ADDR = 8'h05;
  localparam logic [7:0] RQ_GET_DESC = 8'h06;
  localparam logic [7:0] RQ_GET_CFG  = 8'h08;
  localparam logic [7:0] RQ_SET_CFG  = 8'h09;
  localparam logic [7:0] DT_DEVICE   = 8'h01;
  localparam logic [7:0] DT_CONFIG   = 8'h02;

  typedef struct packed {
    logic [7:0]  rtype;
    logic [7:0]  code;
    logic [15:0] value;
    logic [15:0] index;
    logic [15:0] length;
  } setup_t;

  typedef enum logic [2:0] {
    ACT_STALL, ACT_DESC, ACT_GET_CFG, ACT_SET_ADDR, ACT_SET_CFG
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_STAT_OUT, ST_STAT_IN, ST_STALL
  } ep0_state_e;
endpackage

// File: rtl/ctl_setup_capture.sv
module ctl_setup_capture
  import ctl_enum_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         valid_i,
  input  logic         first_i,
  input  logic [7:0]   byte_i,
  output logic         done_o,
  output setup_t       setup_o
);
  localparam int CNT_W = $clog2(SETUP_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SETUP_BYTES - 1);

  logic [7:0]       bytes_q [SETUP_BYTES];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      for (int i = 0; i < SETUP_BYTES; i++) bytes_q[i] <= '0;
    end else begin
      done_o <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (valid_i && first_i) begin
        bytes_q[0] <= byte_i;
        cnt_q      <= CNT_W'(1);
      end else if (valid_i && cnt_q != '0) begin
        bytes_q[cnt_q] <= byte_i;
        if (cnt_q == LAST_IDX) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // little-endian field assembly
  assign setup_o = '{rtype:  bytes_q[0],
                     code:   bytes_q[1],
                     value:  {bytes_q[3], bytes_q[2]},
                     index:  {bytes_q[5], bytes_q[4]},
                     length: {bytes_q[7], bytes_q[6]}};

  a_r2_done_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));
endmodule

// File: rtl/ctl_req_decode.sv
module ctl_req_decode
  import ctl_enum_pkg::*;
#(
  parameter logic [7:0] CFG_VALUE = 8'd1
) (
  input  setup_t            setup_i,
  output act_e              act_o,
  output logic [ROM_AW-1:0] base_o,
  output logic [7:0]        count_o,
  output logic [6:0]        new_addr_o,
  output logic [7:0]        new_cfg_o
);
  logic [7:0] len;

  always_comb begin
    act_o  = ACT_STALL;
    base_o = '0;
    len    = '0;
    unique case ({setup_i.rtype, setup_i.code})
      {RT_STD_IN, RQ_GET_DESC}: begin
        if (setup_i.index == '0 && setup_i.value[7:0] == '0) begin
          if (setup_i.value[15:8] == DT_DEVICE) begin
            act_o = ACT_DESC;
            len   = 8'(DEV_LEN);
          end else if (setup_i.value[15:8] == DT_CONFIG) begin
            act_o  = ACT_DESC;
            base_o = ROM_AW'(DEV_LEN);
            len    = 8'(CFG_LEN);
          end
        end
      end
      {RT_STD_IN, RQ_GET_CFG}: begin
        if (setup_i.value == '0 && setup_i.index == '0) begin
          act_o = ACT_GET_CFG;
          len   = 8'd1;
        end
      end
      {RT_STD_OUT, RQ_SET_ADDR}: begin
        if (setup_i.value[15:7] == '0 && setup_i.index == '0 && setup_i.length == '0)
          act_o = ACT_SET_ADDR;
      end
      {RT_STD_OUT, RQ_SET_CFG}: begin
        if (setup_i.value[15:8] == '0 && setup_i.index == '0 && setup_i.length == '0 &&
            (setup_i.value[7:0] == '0 || setup_i.value[7:0] == CFG_VALUE))
          act_o = ACT_SET_CFG;
      end
      default: act_o = ACT_STALL;
    endcase
  end

  assign count_o    = (setup_i.length < {8'h00, len}) ? setup_i.length[7:0] : len;
  assign new_addr_o = setup_i.value[6:0];
  assign new_cfg_o  = setup_i.value[7:0];
endmodule

// File: rtl/ctl_desc_rom.sv
module ctl_desc_rom
  import ctl_enum_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1234,
  parameter logic [15:0] PRODUCT_ID  = 16'h5678,
  parameter logic [7:0]  EP0_MAX_PKT = 8'd64,
  parameter logic [7:0]  CFG_VALUE   = 8'd1
) (
  input  logic [ROM_AW-1:0] addr_i,
  output logic [7:0]        data_o
);
  logic [ROM_AW-1:0] cfg_off;
  assign cfg_off = addr_i - ROM_AW'(DEV_LEN);

  always_comb begin
    data_o = 8'h00;
    if (addr_i < ROM_AW'(DEV_LEN)) begin
      unique case (addr_i)
        'd0:  data_o = 8'(DEV_LEN);
        'd1:  data_o = DT_DEVICE;
        'd2:  data_o = 8'h10;           // spec release 1.10
        'd3:  data_o = 8'h01;
        'd7:  data_o = EP0_MAX_PKT;
        'd8:  data_o = VENDOR_ID[7:0];
        'd9:  data_o = VENDOR_ID[15:8];
        'd10: data_o = PRODUCT_ID[7:0];
        'd11: data_o = PRODUCT_ID[15:8];
        'd13: data_o = 8'h01;
        'd17: data_o = 8'h01;           // one configuration
        default: data_o = 8'h00;
      endcase
    end else if (addr_i < ROM_AW'(ROM_DEPTH)) begin
      unique case (cfg_off)
        'd0:  data_o = 8'd9;
        'd1:  data_o = DT_CONFIG;
        'd2:  data_o = 8'(CFG_LEN);
        'd4:  data_o = 8'd1;            // interfaces
        'd5:  data_o = CFG_VALUE;
        'd7:  data_o = 8'h80;           // bus powered
        'd8:  data_o = 8'd50;           // 100 mA
        'd9:  data_o = 8'd9;            // interface descriptor
        'd10: data_o = 8'h04;
        'd13: data_o = 8'd1;            // endpoints
        'd14: data_o = 8'hFF;           // vendor class
        'd18: data_o = 8'd7;            // endpoint descriptor
        'd19: data_o = 8'h05;
        'd20: data_o = 8'h81;           // EP1 IN
        'd21: data_o = 8'h02;           // bulk
        'd22: data_o = EP0_MAX_PKT;
        default: data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/ctl_enum_responder.sv
module ctl_enum_responder
  import ctl_enum_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1234,
  parameter logic [15:0] PRODUCT_ID  = 16'h5678,
  parameter logic [7:0]  EP0_MAX_PKT = 8'd64,
  parameter logic [7:0]  CFG_VALUE   = 8'd1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_reset_i,
  input  logic       setup_valid_i,
  input  logic       setup_first_i,
  input  logic [7:0] setup_byte_i,
  input  logic       in_ready_i,
  output logic       in_valid_o,
  output logic [7:0] in_data_o,
  output logic       in_last_o,
  output logic       status_in_o,
  output logic       status_out_o,
  input  logic       status_ack_i,
  output logic       stall_o,
  output logic [6:0] dev_addr_o,
  output logic [7:0] config_o
);
  setup_t            setup;
  logic              setup_done;
  act_e              act;
  logic [ROM_AW-1:0] base;
  logic [7:0]        count;
  logic [6:0]        new_addr;
  logic [7:0]        new_cfg;
  logic [7:0]        rom_data;

  ep0_state_e        state_q;
  logic [ROM_AW-1:0] ptr_q;
  logic [7:0]        remain_q;
  logic              cfg_reply_q;
  logic [6:0]        addr_pend_q;
  logic              addr_pend_v_q;
  logic              new_setup;

  assign new_setup = setup_valid_i && setup_first_i;

  ctl_setup_capture u_capture (
    .clk_i, .rst_ni,
    .clear_i (bus_reset_i),
    .valid_i (setup_valid_i),
    .first_i (setup_first_i),
    .byte_i  (setup_byte_i),
    .done_o  (setup_done),
    .setup_o (setup)
  );

  ctl_req_decode #(.CFG_VALUE(CFG_VALUE)) u_decode (
    .setup_i    (setup),
    .act_o      (act),
    .base_o     (base),
    .count_o    (count),
    .new_addr_o (new_addr),
    .new_cfg_o  (new_cfg)
  );

  ctl_desc_rom #(
    .VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID),
    .EP0_MAX_PKT(EP0_MAX_PKT), .CFG_VALUE(CFG_VALUE)
  ) u_rom (
    .addr_i (ptr_q),
    .data_o (rom_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      ptr_q         <= '0;
      remain_q      <= '0;
      cfg_reply_q   <= 1'b0;
      addr_pend_q   <= '0;
      addr_pend_v_q <= 1'b0;
      dev_addr_o    <= '0;
      config_o      <= '0;
    end else if (bus_reset_i) begin
      state_q       <= ST_IDLE;
      remain_q      <= '0;
      addr_pend_v_q <= 1'b0;
      dev_addr_o    <= '0;
      config_o      <= '0;
    end else if (new_setup) begin
      state_q       <= ST_IDLE;      // abort whatever stage was running
      remain_q      <= '0;
      addr_pend_v_q <= 1'b0;
    end else if (setup_done) begin
      unique case (act)
        ACT_DESC, ACT_GET_CFG: begin
          ptr_q       <= base;
          remain_q    <= count;
          cfg_reply_q <= (act == ACT_GET_CFG);
          state_q     <= (count == '0) ? ST_STAT_OUT : ST_DATA;
        end
        ACT_SET_ADDR: begin
          addr_pend_q   <= new_addr;
          addr_pend_v_q <= 1'b1;
          state_q       <= ST_STAT_IN;
        end
        ACT_SET_CFG: begin
          config_o <= new_cfg;
          state_q  <= ST_STAT_IN;
        end
        default: state_q <= ST_STALL;
      endcase
    end else begin
      unique case (state_q)
        ST_DATA: if (in_ready_i) begin
          ptr_q    <= ptr_q + ROM_AW'(1);
          remain_q <= remain_q - 8'd1;
          if (remain_q == 8'd1) state_q <= ST_STAT_OUT;
        end
        ST_STAT_OUT: if (status_ack_i) state_q <= ST_IDLE;
        ST_STAT_IN: if (status_ack_i) begin
          state_q <= ST_IDLE;
          if (addr_pend_v_q) dev_addr_o <= addr_pend_q;
          addr_pend_v_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign in_valid_o   = (state_q == ST_DATA);
  assign in_data_o    = cfg_reply_q ? config_o : rom_data;
  assign in_last_o    = in_valid_o && (remain_q == 8'd1);
  assign status_out_o = (state_q == ST_STAT_OUT);
  assign status_in_o  = (state_q == ST_STAT_IN);
  assign stall_o      = (state_q == ST_STALL);

  a_r7_addr_moves_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_addr_o != $past(dev_addr_o)) |-> ($past(status_ack_i) || $past(bus_reset_i)));
  a_r12_bus_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (dev_addr_o == '0 && config_o == '0));
  a_r6_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_last_o |-> in_valid_o);
  a_r13_hold_under_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_o && !in_ready_i && !bus_reset_i && !new_setup && !setup_done)
      |=> (in_valid_o && $stable(in_data_o)));
  a_r10_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_valid_o, status_in_o, status_out_o, stall_o}));
  a_r5_single_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_q <= EP0_MAX_PKT);
endmodule

// File: tb/ctl_enum_responder_bench.sv
module ctl_enum_responder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       setup_valid = 1'b0;
  logic       setup_first = 1'b0;
  logic [7:0] setup_byte = '0;
  logic       in_ready = 1'b0;
  logic       in_valid, in_last, status_in, status_out, stall;
  logic [7:0] in_data;
  logic       status_ack = 1'b0;
  logic [6:0] dev_addr;
  logic [7:0] config_val;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] dbuf [64];
  int         dcount;
  int         last_at;
  int         last_cnt;

  always #2 clk = ~clk;

  ctl_enum_responder u_ctl_enum_responder (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset),
    .setup_valid_i(setup_valid), .setup_first_i(setup_first), .setup_byte_i(setup_byte),
    .in_ready_i(in_ready), .in_valid_o(in_valid), .in_data_o(in_data), .in_last_o(in_last),
    .status_in_o(status_in), .status_out_o(status_out), .status_ack_i(status_ack),
    .stall_o(stall), .dev_addr_o(dev_addr), .config_o(config_val)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_setup(input logic [7:0] rt, input logic [7:0] rq,
                            input logic [15:0] val, input logic [15:0] idx,
                            input logic [15:0] len);
    logic [7:0] b [8];
    b = '{rt, rq, val[7:0], val[15:8], idx[7:0], idx[15:8], len[7:0], len[15:8]};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      setup_valid = 1'b1;
      setup_first = (i == 0);
      setup_byte  = b[i];
    end
    @(negedge clk);
    setup_valid = 1'b0;
    setup_first = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_data();
    dcount = 0; last_at = -1; last_cnt = 0;
    in_ready = 1'b1;
    for (int g = 0; g < 100; g++) begin
      if (status_out || stall || status_in) break;
      if (in_valid) begin
        if (in_last) begin last_at = dcount; last_cnt++; end
        dbuf[dcount] = in_data;
        dcount++;
      end
      @(negedge clk);
    end
    in_ready = 1'b0;
  endtask

  task automatic ack_status();
    status_ack = 1'b1;
    @(negedge clk);
    status_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "dev_addr", dev_addr, 0);
    chk("R1", "config", config_val, 0);
    chk("R1", "phases", {in_valid, status_in, status_out, stall}, 0);
  endtask

  task automatic t_device_desc();
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0040);
    read_data();
    chk("R3", "device length", dcount, 18);
    chk("R3", "bLength", dbuf[0], 18);
    chk("R3", "type", dbuf[1], 1);
    chk("R3", "max packet", dbuf[7], 64);
    chk("R3", "vendor id", {dbuf[9], dbuf[8]}, 16'h1234);
    chk("R3", "product id", {dbuf[11], dbuf[10]}, 16'h5678);
    chk("R6", "last index", last_at, 17);
    chk("R6", "last count", last_cnt, 1);
    chk("R6", "status_out", status_out, 1);
    ack_status();
    chk("R6", "idle after ack", {in_valid, status_in, status_out, stall}, 0);
  endtask

  task automatic t_config_desc();
    send_setup(8'h80, 8'h06, 16'h0200, 16'h0000, 16'h00FF);
    read_data();
    chk("R4", "config length", dcount, 25);
    chk("R4", "bLength", dbuf[0], 9);
    chk("R4", "type", dbuf[1], 2);
    chk("R4", "total length", {dbuf[3], dbuf[2]}, 25);
    chk("R4", "interface hdr", {dbuf[9], dbuf[10]}, 16'h0904);
    chk("R4", "endpoint hdr", {dbuf[18], dbuf[19]}, 16'h0705);
    ack_status();
  endtask

  task automatic t_truncate();
    send_setup(8'h80, 8'h06, 16'h0200, 16'h0000, 16'h0009);
    read_data();
    chk("R5", "short reply", dcount, 9);
    chk("R5", "last at 9th", last_at, 8);
    ack_status();
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0000);
    chk("R5", "zero length no data", in_valid, 0);
    chk("R5", "zero length status", status_out, 1);
    ack_status();
    // byte order: 0x0100 = 256 must not read as 1
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0100);
    read_data();
    chk("R2", "length high byte", dcount, 18);
    ack_status();
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0002);
    read_data();
    chk("R2", "length low byte", dcount, 2);
    ack_status();
  endtask

  task automatic t_backpressure();
    logic [7:0] first;
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0012);
    first = in_data;
    repeat (4) @(negedge clk);
    chk("R13", "valid held", in_valid, 1);
    chk("R13", "data held", in_data, first);
    read_data();
    chk("R13", "full reply after stall", dcount, 18);
    ack_status();
  endtask

  task automatic t_set_address();
    send_setup(8'h00, 8'h05, 16'h002A, 16'h0000, 16'h0000);
    chk("R7", "status_in", status_in, 1);
    chk("R7", "addr before ack", dev_addr, 0);
    repeat (3) @(negedge clk);
    chk("R7", "addr still old", dev_addr, 0);
    ack_status();
    chk("R7", "addr after ack", dev_addr, 8'h2A);
  endtask

  task automatic t_set_config();
    send_setup(8'h00, 8'h09, 16'h0001, 16'h0000, 16'h0000);
    chk("R8", "config set", config_val, 1);
    chk("R8", "status_in", status_in, 1);
    ack_status();
    send_setup(8'h80, 8'h08, 16'h0000, 16'h0000, 16'h0001);
    read_data();
    chk("R9", "get config count", dcount, 1);
    chk("R9", "get config value", dbuf[0], 1);
    ack_status();
    send_setup(8'h00, 8'h09, 16'h0005, 16'h0000, 16'h0000);
    chk("R8", "bad value stalls", stall, 1);
    chk("R8", "config kept", config_val, 1);
  endtask

  task automatic t_unsupported();
    send_setup(8'h00, 8'h03, 16'h0001, 16'h0000, 16'h0000);
    chk("R10", "set feature stalls", stall, 1);
    repeat (5) @(negedge clk);
    chk("R10", "stall holds", stall, 1);
    send_setup(8'h80, 8'h06, 16'h0300, 16'h0000, 16'h00FF);
    chk("R10", "string type stalls", stall, 1);
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0409, 16'h00FF);
    chk("R10", "nonzero index stalls", stall, 1);
    send_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0004);
    chk("R10", "stall cleared by setup", stall, 0);
    read_data();
    chk("R10", "served after stall", dcount, 4);
    ack_status();
  endtask

  task automatic t_abort();
    send_setup(8'h80, 8'h06, 16'h0200, 16'h0000, 16'h00FF);
    in_ready = 1'b1;
    repeat (3) @(negedge clk);
    in_ready = 1'b0;
    send_setup(8'h00, 8'h09, 16'h0000, 16'h0000, 16'h0000);
    chk("R11", "data aborted", in_valid, 0);
    chk("R11", "new request served", status_in, 1);
    chk("R11", "new config", config_val, 0);
    ack_status();
  endtask

  task automatic t_bus_reset();
    send_setup(8'h00, 8'h09, 16'h0001, 16'h0000, 16'h0000);
    ack_status();
    chk("R12", "config before", config_val, 1);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    @(negedge clk);
    chk("R12", "addr cleared", dev_addr, 0);
    chk("R12", "config cleared", config_val, 0);
    chk("R12", "idle", {in_valid, status_in, status_out, stall}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_device_desc();
    t_config_desc();
    t_truncate();
    t_backpressure();
    t_set_address();
    t_set_config();
    t_unsupported();
    t_abort();
    t_bus_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule